// File: doc/BRIEF.md
# Compare-Match Event Timer

This is a register-mapped timer that raises an interrupt when its counter reaches a programmed value. It has an up-counter that wraps, a match register, a two-bit control register and a write-only zeroing register. All four sit on a simple word-addressed bus with a two-bit word index. Writes are strobed. Reads are combinational from the addressed word.

The counter advances only on clock cycles where the `tick_i` strobe is high. This lets one clock serve either a slow or a fast timebase with no second clock domain. When the timer is running, the comparison uses the value the counter is about to take. On a hit, a single-cycle interrupt pulse appears on the next clock. An optional control bit returns the counter to zero on a hit instead of loading the match value.

The intended set-up sequence is: stop the timer, zero the count, load the match register with all-ones, then enable. Software may read the count or rewrite the match value at any time.

Top module: `cmtimer`

## Requirements
- R1: After reset the count is 0, the match register is all-ones, the control register is 0 and `irq_o` is low.
- R2: Reads are selected by the word index. Index 0 returns the match register, 1 the live count, 2 the control bits in bits [1:0] with all other bits zero, and 3 returns zero.
- R3: A write to index 3 makes the count read 0 on the following cycle. It takes priority over counting, and no hit is detected in that cycle.
- R4: The count advances by one on each clock where control bit 0 (run) is set and `tick_i` is high. In every other case it holds. It wraps from all-ones to zero.
- R5: When run is set, `tick_i` is high and the incremented count equals the match register, `irq_o` is high for exactly the following clock cycle.
- R6: With run clear, `irq_o` stays low whatever the match and count values.
- R7: `irq_o` is never high on two consecutive cycles. A hit in the cycle right after a pulse produces no second pulse.
- R8: With control bit 1 (zero-on-hit) and run both set, a hit loads the counter with 0 instead of the match value.
- R9: Writes to index 0 and index 2 take effect on the following cycle. A match value the count has already passed produces a hit only after the count wraps around to it.
- R10: Bits of a control write above bit 1 are ignored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Word index of the register |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for the word at `addr_i` |
| irq_o | output | 1 | Expiry pulse, one cycle wide |

## Verification
The assertions assume that `addr_i`, `wr_i` and `tick_i` are known on every sampled edge. They also assume that a write and a tick arriving in the same cycle are legal and resolved by the priority in R3. The bench drives every input at the falling edge, so each value is stable across the rising edge. It uses an 8-bit counter so that a sweep can cover every match value through a full wrap with both control modes. It then applies a pseudo-random mix of writes to all four words and sparse ticks.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MATCH = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_ZERO  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic zero_on_hit;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CNT_W-1:0]  match_o,
    output ctrl_t             ctrl_o,
    output logic              zero_o,
    output logic [CNT_W-1:0]  rdata_o
);
    typedef struct packed {
        logic [CNT_W-1:0] match;
        ctrl_t            ctrl;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        r_d = r_q;
        if (wr_i && sel == SEL_MATCH) r_d.match = wdata_i;
        if (wr_i && sel == SEL_CTRL)  r_d.ctrl  = ctrl_t'(wdata_i[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.match <= '1;
            r_q.ctrl  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_MATCH: rdata_o = r_q.match;
            SEL_COUNT: rdata_o = count_i;
            SEL_CTRL:  rdata_o[CTRL_W-1:0] = r_q.ctrl;
            default:   rdata_o = '0;
        endcase
    end

    assign match_o = r_q.match;
    assign ctrl_o  = r_q.ctrl;
    assign zero_o  = wr_i && (sel == SEL_ZERO);

    a_r9_match_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd0) |=> (match_o == $past(wdata_i)));

    a_r10_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd2) |=> (ctrl_o == $past(wdata_i[1:0])));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] next_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t c_d, c_q;

    assign next_o = c_q.count + CNT_W'(1);

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d.count = '0;
        end else if (run_i && tick_i) begin
            c_d.count = reload_i ? '0 : next_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o = c_q.count;

    a_r3_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_i && tick_i) && !clr_i) |=> $stable(count_o));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !clr_i && !reload_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !clr_i) |=> (count_o == '0));
endmodule

// File: rtl/cmt_compare.sv
module cmt_compare #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             zero_on_hit_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] next_i,
    input  logic [CNT_W-1:0] match_i,
    output logic             reload_o,
    output logic             irq_o
);
    typedef struct packed {
        logic irq;
    } cmp_t;

    cmp_t s_d, s_q;
    logic hit;

    assign hit      = run_i && tick_i && !clr_i && (next_i == match_i);
    assign reload_o = hit && zero_on_hit_i;

    always_comb begin
        s_d     = s_q;
        s_d.irq = hit && !s_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;

    a_r5_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(run_i && tick_i && next_i == match_i));

    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(run_i));
endmodule

// File: rtl/cmtimer.sv
module cmtimer
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] count, next, match;
    ctrl_t            ctrl;
    logic             zero_wr, reload;

    cmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .count_i (count),
        .match_o (match),
        .ctrl_o  (ctrl),
        .zero_o  (zero_wr),
        .rdata_o (rdata_o)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl.run),
        .tick_i   (tick_i),
        .clr_i    (zero_wr),
        .reload_i (reload),
        .count_o  (count),
        .next_o   (next)
    );

    cmt_compare #(.CNT_W(CNT_W)) u_compare (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (ctrl.run),
        .zero_on_hit_i (ctrl.zero_on_hit),
        .tick_i        (tick_i),
        .clr_i         (zero_wr),
        .next_i        (next),
        .match_i       (match),
        .reload_o      (reload),
        .irq_o         (irq_o)
    );
endmodule

// File: tb/cmtimer_test.sv
module cmtimer_test;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         wr_i = 1'b0;
    logic [1:0]   addr_i = 2'd0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_match = '1;
    logic [1:0]   m_ctrl = '0;
    logic         m_irq = 1'b0;
    logic         prev_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmtimer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_match;
            2'd1:    return m_cnt;
            2'd2:    return W'(m_ctrl);
            default: return '0;
        endcase
    endfunction

    // one clock: drive, update the model at the edge, compare after the edge
    task automatic cyc(input logic we, input logic [1:0] a, input logic [W-1:0] d, input logic tk);
        logic         clr, hit, n_irq;
        logic [W-1:0] nx;
        wr_i = we; addr_i = a; wdata_i = d; tick_i = tk;
        @(posedge clk);
        clr   = we && a == 2'd3;
        nx    = m_cnt + 1'b1;
        hit   = m_ctrl[0] && tk && !clr && nx == m_match;
        n_irq = hit && !m_irq;
        if (clr) m_cnt = '0;
        else if (m_ctrl[0] && tk) m_cnt = (hit && m_ctrl[1]) ? '0 : nx;
        if (we && a == 2'd0) m_match = d;
        if (we && a == 2'd2) m_ctrl = d[1:0];
        m_irq = n_irq;
        @(negedge clk);
        chk("R5 irq", 32'(irq_o), 32'(m_irq));
        if (irq_o && prev_irq) chk("R7 back-to-back", 32'(1), 32'(0));
        prev_irq = irq_o;
        case (a)
            2'd0:    chk("R9 match read", 32'(rdata_o), 32'(model_read(a)));
            2'd1:    chk("R4 count read", 32'(rdata_o), 32'(model_read(a)));
            2'd2:    chk("R10 ctrl read", 32'(rdata_o), 32'(model_read(a)));
            default: chk("R2 zero word read", 32'(rdata_o), 32'(model_read(a)));
        endcase
        wr_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int pulses, gap;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 map
        chk("R1 irq after reset", 32'(irq_o), 32'(0));
        addr_i = 2'd0; #1 chk("R1 match reset", 32'(rdata_o), 32'(8'hFF));
        addr_i = 2'd1; #1 chk("R1 count reset", 32'(rdata_o), 32'(0));
        addr_i = 2'd2; #1 chk("R1 ctrl reset", 32'(rdata_o), 32'(0));
        addr_i = 2'd3; #1 chk("R2 word 3 reads zero", 32'(rdata_o), 32'(0));
        @(negedge clk);

        // R10 upper control bits dropped
        cyc(1, 2'd2, 8'hFC, 0);
        chk("R10 upper bits ignored", 32'(rdata_o), 32'(0));
        cyc(1, 2'd2, 8'hFF, 0);
        chk("R10 low bits kept", 32'(rdata_o), 32'(3));
        cyc(1, 2'd2, 8'h00, 0);

        // R3 clear wins over a tick, no hit that cycle
        cyc(1, 2'd0, 8'd6, 0);
        cyc(1, 2'd2, 8'd1, 0);
        repeat (5) cyc(0, 2'd1, 0, 1);
        cyc(1, 2'd3, 0, 1);
        chk("R3 no hit on clear", 32'(irq_o), 32'(0));
        cyc(0, 2'd1, 0, 0);
        chk("R3 count zeroed", 32'(rdata_o), 32'(0));

        // R6 disabled: no irq, count frozen
        cyc(1, 2'd2, 8'd0, 0);
        cyc(1, 2'd0, 8'd1, 0);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(0, 2'd1, 0, 1);
            if (irq_o) pulses++;
        end
        chk("R6 no irq when stopped", 32'(pulses), 32'(0));
        chk("R4 count held when stopped", 32'(rdata_o), 32'(0));

        // R8 zero-on-hit
        cyc(1, 2'd0, 8'd4, 0);
        cyc(1, 2'd2, 8'd3, 0);
        repeat (4) cyc(0, 2'd1, 0, 1);
        chk("R8 count reloaded", 32'(rdata_o), 32'(0));
        chk("R8 irq on hit", 32'(irq_o), 32'(1));

        // R7 hit every tick with match 1 and reload: pulses alternate
        cyc(1, 2'd0, 8'd1, 0);
        cyc(1, 2'd3, 0, 0);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(0, 2'd1, 0, 1);
            if (irq_o) pulses++;
        end
        chk("R7 alternating pulses", 32'(pulses), 32'(5));

        // R9 passed match fires only after wrap
        cyc(1, 2'd2, 8'd1, 0);
        cyc(1, 2'd3, 0, 0);
        repeat (10) cyc(0, 2'd1, 0, 1);
        cyc(1, 2'd0, 8'd5, 0);
        gap = 0;
        for (int i = 0; i < 300; i++) begin
            cyc(0, 2'd1, 0, 1);
            gap++;
            if (irq_o) break;
        end
        chk("R9 hit after wrap", 32'(gap), 32'(251));
        chk("R4 wrapped count", 32'(rdata_o), 32'(5));

        // sweep every match value through a full wrap, both modes
        for (int m = 0; m < 256; m++) begin
            cyc(1, 2'd2, 8'd0, 0);
            cyc(1, 2'd3, 0, 0);
            cyc(1, 2'd0, W'(m), 0);
            cyc(1, 2'd2, (m % 2) ? 8'd3 : 8'd1, 0);
            pulses = 0;
            for (int i = 0; i < 258; i++) begin
                cyc(0, 2'd1, 0, 1);
                if (irq_o) pulses++;
            end
            if (m > 2 || m == 0) chk("R5 pulses per sweep", 32'(pulses > 0), 32'(1));
        end

        // pseudo-random traffic
        lfsr = 16'hACE1;
        cyc(1, 2'd2, 8'd1, 0);
        for (int i = 0; i < 20000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] & lfsr[1] & lfsr[2], lfsr[4:3], lfsr[15:8], lfsr[5] | lfsr[6]);
        end

        summary();
    end
endmodule